// File: doc/BRIEF.md
# Analog Interface Macro Power-Up Sequencer

This block brings an analog I/O interface macro up and down in a fixed, timed order. The macro has two control lines: an active-high power enable (`pwr_en_o`, the inverse of a power-down control) and a delay-line enable (`dll_en_o`). It also reports two status bits: calibration finished (`cal_done_i`) and delay-line locked (`dll_lock_i`). A one-cycle request on `pwr_on_req_i` or `pwr_off_req_i` starts a sequence. `busy_o` is high while a power-up sequence is running. `done_o` pulses once when any sequence ends, and `err_o` with `err_code_o` reports how it ended.

Any request first drives both control lines low, which lets the calibration state machine inside the macro initialise. A power-down request stops there and reports success.

A power-up then proceeds step by step:
- Wait a hold time, then raise the power enable.
- Wait a calibration time, then sample calibration-finished once.
- If calibration has finished, raise the delay-line enable.
- Wait a lock time, then sample the lock status once.

A status bit that is not set at its sample point ends the sequence with a timeout code. The control lines then keep the values they had. All waits are whole microseconds converted to clock cycles through the parameter `CYC_PER_US`. One down-counter is shared by all the waits.

Top module: `phy_pwrseq`

## Requirements
- R1: A request accepted in idle drives `pwr_en_o` and `dll_en_o` low and clears `err_code_o` to 00, all at the accepting clock edge.
- R2: A power-down request ends at its accepting edge: `done_o` is high for the following cycle, `busy_o` stays low and `err_code_o` is 00.
- R3: After a power-up request is accepted, `pwr_en_o` rises exactly HOLD_US*CYC_PER_US cycles later (default 3 us). `busy_o` is high from the accepting edge on.
- R4: `cal_done_i` is sampled once, CAL_US*CYC_PER_US cycles after `pwr_en_o` rises. If it is 0, the sequence ends with code 01, `pwr_en_o` stays 1 and `dll_en_o` stays 0.
- R5: If `cal_done_i` is 1 at its sample, `dll_en_o` rises at that edge. `dll_lock_i` is sampled LOCK_US*CYC_PER_US cycles later (default 11 us): 1 ends the sequence with code 00, 0 ends it with code 10, and both control lines stay 1 in either case.
- R6: `pwr_on_req_i` and `pwr_off_req_i` are ignored while `busy_o` is high; the running sequence's timing and result do not change.
- R7: `done_o` is a one-cycle pulse. It rises at the edge where `busy_o` falls, or at the accepting edge of a power-down request.
- R8: `err_o` is high exactly when `err_code_o` is not 00. The code holds its value until the next request is accepted.
- R9: If both requests arrive in the same idle cycle, the power-down request wins.
- R10: Reset drives `pwr_en_o`, `dll_en_o`, `busy_o`, `done_o` and `err_code_o` low and returns the sequencer to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pwr_on_req_i | input | 1 | One-cycle power-up request |
| pwr_off_req_i | input | 1 | One-cycle power-down request |
| cal_done_i | input | 1 | Calibration-finished status from the macro |
| dll_lock_i | input | 1 | Delay-line lock status from the macro |
| pwr_en_o | output | 1 | Power enable to the macro (high = powered) |
| dll_en_o | output | 1 | Delay-line enable to the macro |
| busy_o | output | 1 | High while a power-up sequence runs |
| done_o | output | 1 | One-cycle pulse at the end of any sequence |
| err_o | output | 1 | High when the last sequence ended in a timeout |
| err_code_o | output | 2 | 00 none, 01 calibration timeout, 10 lock timeout |

## Verification
Some properties are checked on every cycle by the assertions:
- The delay-line enable is never high without the power enable.
- Both control lines are low whenever busy rises.
- The delay-line enable only rises after calibration-finished was seen set.
- An error only appears together with the done pulse.
- The shared counter only steps down by one.

Other behaviour can only be shown by the bench's scenarios:
- The exact cycle distances of the three waits.
- The choice between the error codes.
- Ignored requests during busy.
- The power-down priority when both requests arrive together.

// File: rtl/phy_pwrseq_pkg.sv
package phy_pwrseq_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_HOLD = 2'd1,
    S_CAL  = 2'd2,
    S_LOCK = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'b00,
    ERR_CAL  = 2'b01,
    ERR_LOCK = 2'b10
  } seq_err_e;

endpackage

// File: rtl/phy_pwrseq_timer.sv
module phy_pwrseq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en = load_i || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)             cnt_d = load_val_i;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R3: without a reload the counter only ever steps down by one
  p_tmr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/phy_pwrseq_fsm.sv
module phy_pwrseq_fsm
  import phy_pwrseq_pkg::*;
#(
  parameter int CW      = 8,
  parameter int HOLD_CY = 300,
  parameter int CAL_CY  = 500,
  parameter int LOCK_CY = 1100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          on_req_i,
  input  logic          off_req_i,
  input  logic          cal_done_i,
  input  logic          dll_lock_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output logic          pwr_en_o,
  output logic          dll_en_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    err_code_o
);

  localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_CY - 1);
  localparam logic [CW-1:0] CAL_LD  = CW'(CAL_CY - 1);
  localparam logic [CW-1:0] LOCK_LD = CW'(LOCK_CY - 1);

  seq_state_e st_q, st_d;
  logic       pwr_q, pwr_d;
  logic       dll_q, dll_d;
  logic       done_q, done_d;
  seq_err_e   code_q, code_d;

  always_comb begin
    st_d       = st_q;
    pwr_d      = pwr_q;
    dll_d      = dll_q;
    done_d     = 1'b0;
    code_d     = code_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = HOLD_LD;
    case (st_q)
      S_IDLE: begin
        if (off_req_i) begin
          pwr_d  = 1'b0;
          dll_d  = 1'b0;
          code_d = ERR_NONE;
          done_d = 1'b1;
        end else if (on_req_i) begin
          pwr_d      = 1'b0;
          dll_d      = 1'b0;
          code_d     = ERR_NONE;
          tmr_load_o = 1'b1;
          tmr_val_o  = HOLD_LD;
          st_d       = S_HOLD;
        end
      end
      S_HOLD: begin
        if (tmr_zero_i) begin
          pwr_d      = 1'b1;
          tmr_load_o = 1'b1;
          tmr_val_o  = CAL_LD;
          st_d       = S_CAL;
        end
      end
      S_CAL: begin
        if (tmr_zero_i) begin
          if (cal_done_i) begin
            dll_d      = 1'b1;
            tmr_load_o = 1'b1;
            tmr_val_o  = LOCK_LD;
            st_d       = S_LOCK;
          end else begin
            code_d = ERR_CAL;
            done_d = 1'b1;
            st_d   = S_IDLE;
          end
        end
      end
      S_LOCK: begin
        if (tmr_zero_i) begin
          if (!dll_lock_i) code_d = ERR_LOCK;
          done_d = 1'b1;
          st_d   = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      pwr_q  <= 1'b0;
      dll_q  <= 1'b0;
      done_q <= 1'b0;
      code_q <= ERR_NONE;
    end else begin
      st_q   <= st_d;
      pwr_q  <= pwr_d;
      dll_q  <= dll_d;
      done_q <= done_d;
      code_q <= code_d;
    end
  end

  assign pwr_en_o   = pwr_q;
  assign dll_en_o   = dll_q;
  assign busy_o     = (st_q != S_IDLE);
  assign done_o     = done_q;
  assign err_code_o = code_q;

  // R5: delay line is never enabled while the macro is powered down
  p_dll_needs_pwr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dll_en_o |-> pwr_en_o);

  // R1: a power-up starts with both control lines low
  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (!pwr_en_o && !dll_en_o));

  // R5: delay line is enabled only after calibration was seen finished
  p_dll_after_cal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dll_en_o) |-> $past(cal_done_i));

  // R7: done never overlaps a running sequence
  p_done_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R8: a new error code only appears together with the done pulse
  p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code_o != 2'b00 && !$stable(err_code_o)) |-> done_o);

endmodule

// File: rtl/phy_pwrseq.sv
module phy_pwrseq #(
  parameter int CYC_PER_US = 100,
  parameter int HOLD_US    = 3,
  parameter int CAL_US     = 5,
  parameter int LOCK_US    = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_on_req_i,
  input  logic       pwr_off_req_i,
  input  logic       cal_done_i,
  input  logic       dll_lock_i,
  output logic       pwr_en_o,
  output logic       dll_en_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o,
  output logic [1:0] err_code_o
);

  localparam int HOLD_CY = HOLD_US * CYC_PER_US;
  localparam int CAL_CY  = CAL_US * CYC_PER_US;
  localparam int LOCK_CY = LOCK_US * CYC_PER_US;
  localparam int MAX_A   = (HOLD_CY > CAL_CY) ? HOLD_CY : CAL_CY;
  localparam int MAX_CY  = (MAX_A > LOCK_CY) ? MAX_A : LOCK_CY;
  localparam int CW      = $clog2(MAX_CY + 1);

  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_zero;

  phy_pwrseq_timer #(.CW(CW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  phy_pwrseq_fsm #(
    .CW      (CW),
    .HOLD_CY (HOLD_CY),
    .CAL_CY  (CAL_CY),
    .LOCK_CY (LOCK_CY)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .on_req_i   (pwr_on_req_i),
    .off_req_i  (pwr_off_req_i),
    .cal_done_i (cal_done_i),
    .dll_lock_i (dll_lock_i),
    .tmr_zero_i (tmr_zero),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .pwr_en_o   (pwr_en_o),
    .dll_en_o   (dll_en_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_code_o (err_code_o)
  );

  assign err_o = (err_code_o != 2'b00);

endmodule

// File: tb/phy_pwrseq_test.sv
`timescale 1ns/1ps
module phy_pwrseq_test;

  localparam int CPU = 10;
  localparam int H   = 3 * CPU;
  localparam int C   = 5 * CPU;
  localparam int L   = 11 * CPU;

  logic       clk;
  logic       rst_n;
  logic       on_req, off_req, cal, lock;
  logic       pwr_en, dll_en, busy, done, err;
  logic [1:0] code;

  int checks = 0;
  int errors = 0;

  phy_pwrseq #(.CYC_PER_US(CPU)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_on_req_i  (on_req),
    .pwr_off_req_i (off_req),
    .cal_done_i    (cal),
    .dll_lock_i    (lock),
    .pwr_en_o      (pwr_en),
    .dll_en_o      (dll_en),
    .busy_o        (busy),
    .done_o        (done),
    .err_o         (err),
    .err_code_o    (code)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int exp_done_idx(bit c, bit k);
    return c ? (H + C + L) : (H + C);
  endfunction

  function automatic logic [1:0] exp_code(bit c, bit k);
    if (!c) return 2'b01;
    if (!k) return 2'b10;
    return 2'b00;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // power-down path (also used for both-requests case)
  task automatic run_off(bit with_on);
    @(negedge clk);
    off_req = 1'b1;
    on_req  = with_on;
    @(posedge clk);
    @(negedge clk);
    off_req = 1'b0;
    on_req  = 1'b0;
    check(pwr_en == 1'b0 && dll_en == 1'b0, "R1 lines low", {pwr_en, dll_en}, 0);
    check(done == 1'b1, with_on ? "R9 done on both" : "R2 done pulse", done, 1);
    check(busy == 1'b0, with_on ? "R9 not busy" : "R2 not busy", busy, 0);
    check(code == 2'b00 && err == 1'b0, "R2 code none", code, 0);
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", done, 0);
    check(busy == 1'b0, "R9 stays idle", busy, 0);
  endtask

  // power-up path; poke >= 0 injects a request at that negedge index
  task automatic run_on(bit c, bit k, int poke, bit poke_off);
    int pwr_idx  = -1;
    int dll_idx  = -1;
    int done_idx = -1;
    int ed       = exp_done_idx(c, k);
    logic [1:0] ec = exp_code(c, k);
    @(negedge clk);
    on_req = 1'b1;
    cal    = c;
    lock   = k;
    @(posedge clk);
    @(negedge clk);
    on_req = 1'b0;
    check(pwr_en == 1'b0 && dll_en == 1'b0, "R1 lines low at accept", {pwr_en, dll_en}, 0);
    check(code == 2'b00 && err == 1'b0, "R8 code cleared on accept", code, 0);
    check(busy == 1'b1, "R3 busy at accept", busy, 1);
    for (int idx = 0; idx < 400; idx++) begin
      if (idx > 0) @(negedge clk);
      on_req  = 1'b0;
      off_req = 1'b0;
      if (pwr_en && pwr_idx < 0)  pwr_idx = idx;
      if (dll_en && dll_idx < 0)  dll_idx = idx;
      if (done) begin
        done_idx = idx;
        break;
      end
      if (idx == poke) begin
        if (poke_off) off_req = 1'b1;
        else          on_req  = 1'b1;
      end
    end
    on_req  = 1'b0;
    off_req = 1'b0;
    check(pwr_idx == H, "R3 power enable delay", pwr_idx, H);
    if (c) check(dll_idx == H + C, "R5 delay-line enable delay", dll_idx, H + C);
    else   check(dll_idx == -1, "R4 delay line stays off", dll_idx, -1);
    check(done_idx == ed, poke >= 0 ? "R6 timing unchanged by ignored request" : "R5 done time",
          done_idx, ed);
    check(code == ec, c ? "R5 result code" : "R4 result code", code, ec);
    check(err == (ec != 2'b00), "R8 err flag", err, ec != 2'b00);
    check(busy == 1'b0, "R7 busy falls with done", busy, 0);
    check(pwr_en == 1'b1 && dll_en == c, "R4 R5 lines hold", {pwr_en, dll_en}, {1'b1, c});
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", done, 0);
    check(code == ec, "R8 code held", code, ec);
    check(busy == 1'b0, "R6 no restart from ignored request", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20161));
    rst_n = 1'b0; on_req = 1'b0; off_req = 1'b0; cal = 1'b0; lock = 1'b0;
    repeat (3) @(negedge clk);
    check(pwr_en == 0 && dll_en == 0 && busy == 0 && done == 0 && code == 0,
          "R10 reset state", {pwr_en, dll_en, busy, done, code}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R10 idle after release", {busy, done}, 0);

    run_on(1'b1, 1'b1, -1, 1'b0);
    run_off(1'b0);
    run_on(1'b0, 1'b1, -1, 1'b0);
    run_on(1'b1, 1'b0, -1, 1'b0);
    run_off(1'b1);
    run_on(1'b1, 1'b1, 5, 1'b1);
    run_on(1'b1, 1'b1, H + C + 3, 1'b0);

    for (int n = 0; n < 24; n++) begin
      bit c  = 1'($urandom);
      bit k  = 1'($urandom);
      bit po = 1'($urandom);
      int pk = ($urandom % 3 == 0) ? -1 : int'($urandom % exp_done_idx(c, k));
      if ($urandom % 5 == 0) run_off(1'($urandom));
      else                   run_on(c, k, pk, po);
    end

    // reset mid-sequence
    @(negedge clk);
    on_req = 1'b1; cal = 1'b1; lock = 1'b1;
    @(negedge clk);
    on_req = 1'b0;
    repeat (H + 2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(pwr_en == 0 && dll_en == 0 && busy == 0 && code == 0,
          "R10 reset mid-sequence", {pwr_en, dll_en, busy, code}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule